// File: doc/BRIEF.md
# Status Flag Register with Byte Transfer

This block holds the condition flags of a small processor datapath: carry, parity, auxiliary carry, zero, sign and overflow. It also holds an interrupt enable flag that gates external interrupts. In normal operation the ALU writes any subset of the six arithmetic flags each cycle through a result bus with a write enable per flag. A command input lets the sequencer act on the flags directly. It can clear, set or invert the carry, and it can clear or set the interrupt enable. It can also move five of the flags to or from an 8-bit accumulator half in a fixed packed layout.

The byte path is used to save the flags to memory and to restore them later. A read command captures the packed flags into a holding register that drives the readback byte. A load command takes the five packed flags from the data byte. Overflow and interrupt enable are outside the packed layout, so neither transfer can change them. Any command other than the idle code has priority over the ALU update in the same cycle, and that ALU update is then dropped entirely.

Top module: `status_flag_reg`

## Requirements
- R1: While rst_ni is low, and on the first cycle after its release, every flag output is 0 and byte_o is 0x02.
- R2: Command 1 (clear carry) makes cf_o 0 on the next cycle, and command 2 (set carry) makes it 1. All other flags stay unchanged.
- R3: Command 3 (invert carry) makes cf_o the inverse of its previous value. All other flags stay unchanged.
- R4: Command 4 makes if_o 0 and command 5 makes if_o 1. The arithmetic flags stay unchanged.
- R5: Command 6 (load byte) sets the flags from data_i: CF from bit 0, PF from bit 2, AF from bit 4, ZF from bit 6, SF from bit 7. Loading 0x1E gives SF=0, ZF=0, AF=1, PF=1, CF=0.
- R6: Command 6 never changes of_o or if_o, and bits 1, 3 and 5 of data_i have no effect.
- R7: Command 7 (read byte) loads byte_o on the next cycle with the packed flags: bit 0 CF, bit 1 constant 1, bit 2 PF, bit 3 0, bit 4 AF, bit 5 0, bit 6 ZF, bit 7 SF. The flags stay unchanged, and byte_o holds its value under every other command.
- R8: With command 0 (idle), each arithmetic flag takes its alu_flags_i bit when the matching alu_we_i bit is 1 and keeps its value otherwise. The bit index is 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF. if_o does not change.
- R9: When the command is not 0, alu_flags_i and alu_we_i have no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Flag command code (0 idle, 1..7 as in requirements) |
| data_i | input | 8 | Byte to load on command 6 |
| alu_flags_i | input | 6 | ALU flag results, index 0 CF .. 5 OF |
| alu_we_i | input | 6 | Per-flag write enables for the ALU results |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Auxiliary carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| if_o | output | 1 | Interrupt enable flag |
| byte_o | output | 8 | Packed flags captured by the last read command |

## Verification
Directed cases come first. Loading 0x1E checks the documented unpacking. A load of 0xFF while OF and IF are set, and a load of 0x2A, show whether OF, IF and the filler bits leak into the load. A read right after the load checks that packing and unpacking match. Random command, data, ALU-result and enable patterns then run. Each command is mixed with active ALU enables, which shows whether a command truly overrides the ALU update or lets some of it through. Idle cycles with sparse enables tell per-flag masking apart from whole-bus writes.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_ARITH = 6;
  localparam int unsigned NUM_PACK  = 5;
  localparam int unsigned CMD_W     = 3;

  // arithmetic flag indices
  localparam int unsigned F_CF = 0;
  localparam int unsigned F_PF = 1;
  localparam int unsigned F_AF = 2;
  localparam int unsigned F_ZF = 3;
  localparam int unsigned F_SF = 4;
  localparam int unsigned F_OF = 5;

  // byte position of packed flag k (flag index k = 0..4)
  localparam int unsigned PACK_POS [NUM_PACK] = '{0, 2, 4, 6, 7};
  localparam logic [BYTE_W-1:0] PACK_FILL = 8'h02;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE  = 3'd0,
    CMD_CLR_C = 3'd1,
    CMD_SET_C = 3'd2,
    CMD_INV_C = 3'd3,
    CMD_CLR_I = 3'd4,
    CMD_SET_I = 3'd5,
    CMD_LOAD  = 3'd6,
    CMD_READ  = 3'd7
  } cmd_e;

  typedef struct packed {
    logic clr_c;
    logic set_c;
    logic inv_c;
    logic clr_i;
    logic set_i;
    logic load;
    logic read;
    logic busy;
  } ctl_t;
endpackage

// File: rtl/sfr_cmd_decode.sv
module sfr_cmd_decode
  import status_flag_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output ctl_t             ctl_o
);
  always_comb begin
    ctl_o       = '0;
    ctl_o.busy  = (cmd_i != CMD_IDLE);
    unique case (cmd_i)
      CMD_CLR_C: ctl_o.clr_c = 1'b1;
      CMD_SET_C: ctl_o.set_c = 1'b1;
      CMD_INV_C: ctl_o.inv_c = 1'b1;
      CMD_CLR_I: ctl_o.clr_i = 1'b1;
      CMD_SET_I: ctl_o.set_i = 1'b1;
      CMD_LOAD:  ctl_o.load  = 1'b1;
      CMD_READ:  ctl_o.read  = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/sfr_byte_pack.sv
module sfr_byte_pack
  import status_flag_pkg::*;
(
  input  logic [NUM_ARITH-1:0] flags_i,
  input  logic [BYTE_W-1:0]    byte_i,
  output logic [BYTE_W-1:0]    byte_o,
  output logic [NUM_PACK-1:0]  unpack_o
);
  logic [NUM_PACK-1:0][BYTE_W-1:0] lane;

  for (genvar k = 0; k < NUM_PACK; k++) begin : g_lane
    always_comb begin
      lane[k]              = '0;
      lane[k][PACK_POS[k]] = flags_i[k];
    end
    assign unpack_o[k] = byte_i[PACK_POS[k]];
  end

  always_comb begin
    byte_o = PACK_FILL;
    for (int k = 0; k < NUM_PACK; k++) byte_o = byte_o | lane[k];
  end
endmodule

// File: rtl/sfr_flag_core.sv
module sfr_flag_core
  import status_flag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  ctl_t                 ctl_i,
  input  logic [NUM_PACK-1:0]  load_i,
  input  logic [NUM_ARITH-1:0] alu_flags_i,
  input  logic [NUM_ARITH-1:0] alu_we_i,
  output logic [NUM_ARITH-1:0] arith_o,
  output logic                 ie_o
);
  logic [NUM_ARITH-1:0] arith_q, arith_d, alu_merge;
  logic                 ie_q, ie_d;

  for (genvar i = 0; i < NUM_ARITH; i++) begin : g_merge
    assign alu_merge[i] = alu_we_i[i] ? alu_flags_i[i] : arith_q[i];
  end

  always_comb begin
    arith_d = arith_q;
    ie_d    = ie_q;
    if (!ctl_i.busy) begin
      arith_d = alu_merge;
    end else begin
      if (ctl_i.load) arith_d[NUM_PACK-1:0] = load_i;
      if (ctl_i.clr_c) arith_d[F_CF] = 1'b0;
      if (ctl_i.set_c) arith_d[F_CF] = 1'b1;
      if (ctl_i.inv_c) arith_d[F_CF] = ~arith_q[F_CF];
      if (ctl_i.clr_i) ie_d = 1'b0;
      if (ctl_i.set_i) ie_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arith_q <= '0;
      ie_q    <= 1'b0;
    end else begin
      arith_q <= arith_d;
      ie_q    <= ie_d;
    end
  end

  assign arith_o = arith_q;
  assign ie_o    = ie_q;

  assert_inv_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.inv_c |=> arith_q[F_CF] != $past(arith_q[F_CF]));
  assert_cmd_blocks_alu_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.busy |=> $stable(arith_q[F_OF]));
  assert_idle_keeps_ie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.busy |=> $stable(ie_q));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_flag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [BYTE_W-1:0]    data_i,
  input  logic [NUM_ARITH-1:0] alu_flags_i,
  input  logic [NUM_ARITH-1:0] alu_we_i,
  output logic                 cf_o,
  output logic                 pf_o,
  output logic                 af_o,
  output logic                 zf_o,
  output logic                 sf_o,
  output logic                 of_o,
  output logic                 if_o,
  output logic [BYTE_W-1:0]    byte_o
);
  ctl_t                 ctl;
  logic [NUM_PACK-1:0]  unpacked;
  logic [NUM_ARITH-1:0] arith;
  logic [BYTE_W-1:0]    packed_now, byte_q;
  logic                 ie;

  sfr_cmd_decode u_dec (.cmd_i(cmd_i), .ctl_o(ctl));

  sfr_byte_pack u_pack (
    .flags_i (arith),
    .byte_i  (data_i),
    .byte_o  (packed_now),
    .unpack_o(unpacked)
  );

  sfr_flag_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl),
    .load_i     (unpacked),
    .alu_flags_i(alu_flags_i),
    .alu_we_i   (alu_we_i),
    .arith_o    (arith),
    .ie_o       (ie)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       byte_q <= PACK_FILL;
    else if (ctl.read) byte_q <= packed_now;
  end

  assign cf_o   = arith[F_CF];
  assign pf_o   = arith[F_PF];
  assign af_o   = arith[F_AF];
  assign zf_o   = arith[F_ZF];
  assign sf_o   = arith[F_SF];
  assign of_o   = arith[F_OF];
  assign if_o   = ie;
  assign byte_o = byte_q;

  assert_clr_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_CLR_C |=> !cf_o);
  assert_set_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_SET_C |=> cf_o);
  assert_clr_int_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_CLR_I |=> !if_o);
  assert_set_int_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_SET_I |=> if_o);
  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_LOAD |=> (cf_o == $past(data_i[0])) && (pf_o == $past(data_i[2]))
      && (af_o == $past(data_i[4])) && (zf_o == $past(data_i[6]))
      && (sf_o == $past(data_i[7])));
  assert_load_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_LOAD |=> $stable(of_o) && $stable(if_o));
  assert_read_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_READ |=> $stable({cf_o, pf_o, af_o, zf_o, sf_o, of_o, if_o})
      && byte_o[1] && !byte_o[3] && !byte_o[5]);
  assert_byte_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i != CMD_READ |=> $stable(byte_o));
endmodule

// File: tb/status_flag_reg_bench.sv
module status_flag_reg_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [7:0] data = 8'h00;
  logic [5:0] alu_f = 6'h0, alu_we = 6'h0;
  logic cf, pf, af, zf, sf, of_f, ie;
  logic [7:0] byte_out;

  int total = 0, bad = 0;
  logic [5:0] m_ar = 6'h0;
  logic       m_ie = 1'b0;
  logic [7:0] m_byte = 8'h02;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  status_flag_reg u_status_flag_reg (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .data_i(data),
    .alu_flags_i(alu_f), .alu_we_i(alu_we),
    .cf_o(cf), .pf_o(pf), .af_o(af), .zf_o(zf), .sf_o(sf), .of_o(of_f),
    .if_o(ie), .byte_o(byte_out)
  );

  function automatic logic [7:0] pack_flags(logic [5:0] a);
    return {a[4], a[3], 1'b0, a[2], 1'b0, a[1], 1'b1, a[0]};
  endfunction

  function automatic string req_of(logic [2:0] c);
    case (c)
      3'd0: return "R8/R9";
      3'd1, 3'd2: return "R2";
      3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      3'd6: return "R5/R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, {1'b0, ie, of_f, sf, zf, af, pf, cf}, {1'b0, m_ie, m_ar[5:4], m_ar[3:0]});
    check(req, byte_out, m_byte);
  endtask

  // model of one clock edge
  task automatic step(logic [2:0] c, logic [7:0] d, logic [5:0] f, logic [5:0] we);
    logic [5:0] nxt = m_ar;
    cmd = c; data = d; alu_f = f; alu_we = we;
    case (c)
      3'd0: nxt = (m_ar & ~we) | (f & we);
      3'd1: nxt[0] = 1'b0;
      3'd2: nxt[0] = 1'b1;
      3'd3: nxt[0] = ~m_ar[0];
      3'd4: m_ie = 1'b0;
      3'd5: m_ie = 1'b1;
      3'd6: nxt[4:0] = {d[7], d[6], d[4], d[2], d[0]};
      default: m_byte = pack_flags(m_ar);
    endcase
    m_ar = nxt;
    @(negedge clk);
    check_all(req_of(c));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    check_all("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R5: documented byte
    step(3'd6, 8'h1E, 6'h3F, 6'h3F);
    check("R5", {3'b0, sf, zf, af, pf, cf}, 8'b0000_0110);
    // R6: OF/IF untouched, filler bits ignored
    step(3'd0, 8'h00, 6'h20, 6'h20);
    step(3'd5, 8'h00, 6'h00, 6'h3F);
    step(3'd6, 8'h2A, 6'h00, 6'h3F);
    check("R6", {6'b0, of_f, ie}, 8'h03);
    step(3'd6, 8'hFF, 6'h00, 6'h3F);
    check("R6", {6'b0, of_f, ie}, 8'h03);
    // R7: pack after load
    step(3'd7, 8'h00, 6'h00, 6'h3F);
    check("R7", byte_out, 8'hD7);
    step(3'd3, 8'h00, 6'h00, 6'h00);
    step(3'd3, 8'h00, 6'h00, 6'h00);
    step(3'd1, 8'h00, 6'h3F, 6'h3F);
    step(3'd4, 8'h00, 6'h3F, 6'h3F);
    step(3'd2, 8'h00, 6'h00, 6'h3F);
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] c = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom % 8);
      step(c, 8'($urandom), 6'($urandom), 6'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule